// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a small register bank that a processor reaches over a plain 32-bit read/write bus inside a 4 KB address window. It exposes a fixed board identification word, an LED register driven straight onto output pins, and two flag words, each with one address that sets bits and another that clears them. It also has a free-running tick counter that advances at a nominal 24 MHz, derived from the bus clock by a fractional accumulator. A constant status word always reads as 1.

A reset-control register can only be written after software stores a 32-bit magic key (0x0000A05F) into the key register. An accepted write with the variant's trigger bit set produces a single-cycle system reset request. The parameter `VARIANT` picks the board flavour. Variant 0 uses bit 8 as the trigger and variant 1 uses bit 2. Variant 2 has no reset-control register: it reads as zero and ignores writes.

Two resets drive the bank. The ordinary reset `rst_n` clears the volatile state. The power-on reset `por_n` is the only reset that clears the non-volatile flag word, so that word survives a system reset the block requests itself.

Top module: `sysctl_bank`

## Requirements
- R1: After reset, `led_o`, `sys_rst_req_o`, `err_o` and `rvalid_o` are 0. The LED, key, flag and reset-control registers read 0, and byte offset 0x000 reads the `BOARD_ID` parameter.
- R2: A write to offset 0x008 stores the data as the LED word. The word appears on `led_o` the cycle after the write and reads back at 0x008.
- R3: A write of exactly 0x0000A05F to offset 0x020 stores 0xA05F. Any other value stores its bits [14:0] with bit 15 cleared. Offset 0x020 reads the stored 16 bits, zero-extended.
- R4: A write to offset 0x040 updates the reset-control word only while the stored key equals 0xA05F. Otherwise it leaves the word unchanged.
- R5: An accepted reset-control write whose trigger bit is 1 raises `sys_rst_req_o` for exactly one cycle, starting on the edge that takes the write. The trigger is bit 8 for variant 0 and bit 2 for variant 1. In variant 2, offset 0x040 reads 0 and never requests a reset.
- R6: A write to 0x030 ORs the data into the flag word, and a write to 0x034 clears every flag bit whose data bit is 1. The flag word reads at 0x030.
- R7: Offsets 0x038 (set) and 0x03C (clear) act the same way on the non-volatile flag word, which reads at 0x038. That word keeps its value through `rst_n` and is cleared only by `por_n`.
- R8: Offset 0x044 always reads 0x00000001. A write to it changes nothing and raises no error.
- R9: Offset 0x05C reads a counter that advances by TICK_HZ/CLK_HZ per clock on average (24 every 100 cycles with the defaults). It never steps by more than 1 per cycle.
- R10: Any access outside this set raises `err_o` for one cycle: a read of an offset other than 0x000, 0x008, 0x020, 0x030, 0x038, 0x040, 0x044 or 0x05C, or a write to an offset other than 0x008, 0x020, 0x030, 0x034, 0x038, 0x03C, 0x040 or 0x044. Such a read returns 0, and such a write changes no state.
- R11: A read sampled with `rd_en_i` on one edge has `rvalid_o` high and `rdata_o` valid after that edge, for one cycle. The data shows register contents from before any write sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset for volatile state |
| por_n | input | 1 | Active-low power-on reset, also clears the non-volatile flags |
| rd_en_i | input | 1 | Read strobe, one access per cycle |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| addr_i | input | ADDR_W | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | Read data valid, one cycle after the read strobe |
| err_o | output | 1 | One-cycle pulse for an access to an undefined offset |
| led_o | output | 32 | LED register contents |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Each result of this bank arrives one register stage after the edge that samples the access. Read data, `rvalid_o`, `err_o`, `sys_rst_req_o` and the new `led_o` value are all due after that single edge. The bench therefore drives every access on a falling edge and judges its outcome on the next falling edge, and the monitor pops one scoreboard entry for every `rvalid_o` it sees. The one-cycle width of the reset request is checked one falling edge later still. The tick rate is checked by sampling the counter twice, exactly 100 cycles apart, and expecting a difference of exactly 24.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned WORD_W = 32;

    // Byte offsets inside the window; software relies on them
    localparam logic [11:0] OFS_ID   = 12'h000;
    localparam logic [11:0] OFS_LED  = 12'h008;
    localparam logic [11:0] OFS_KEY  = 12'h020;
    localparam logic [11:0] OFS_FSET = 12'h030;
    localparam logic [11:0] OFS_FCLR = 12'h034;
    localparam logic [11:0] OFS_NSET = 12'h038;
    localparam logic [11:0] OFS_NCLR = 12'h03C;
    localparam logic [11:0] OFS_RCTL = 12'h040;
    localparam logic [11:0] OFS_ONE  = 12'h044;
    localparam logic [11:0] OFS_TICK = 12'h05C;

    localparam logic [WORD_W-1:0] KEY_WORD = 32'h0000_A05F;
    localparam logic [15:0]       KEY16    = 16'hA05F;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LED,
        SEL_KEY,
        SEL_FSET,
        SEL_FCLR,
        SEL_NSET,
        SEL_NCLR,
        SEL_RCTL,
        SEL_ONE,
        SEL_TICK
    } sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] led;
        logic [15:0]       key;
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] rctl;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
        logic              err;
        logic              rst_req;
    } bank_state_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o,
    output logic              rd_legal_o,
    output logic              wr_legal_o
);

    always_comb begin
        sel_o      = SEL_NONE;
        rd_legal_o = 1'b0;
        wr_legal_o = 1'b0;
        if      (addr_i == ADDR_W'(OFS_ID))   begin sel_o = SEL_ID;   rd_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_LED))  begin sel_o = SEL_LED;  rd_legal_o = 1'b1; wr_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_KEY))  begin sel_o = SEL_KEY;  rd_legal_o = 1'b1; wr_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_FSET)) begin sel_o = SEL_FSET; rd_legal_o = 1'b1; wr_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_FCLR)) begin sel_o = SEL_FCLR; wr_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_NSET)) begin sel_o = SEL_NSET; rd_legal_o = 1'b1; wr_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_NCLR)) begin sel_o = SEL_NCLR; wr_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_RCTL)) begin sel_o = SEL_RCTL; rd_legal_o = 1'b1; wr_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_ONE))  begin sel_o = SEL_ONE;  rd_legal_o = 1'b1; wr_legal_o = 1'b1; end
        else if (addr_i == ADDR_W'(OFS_TICK)) begin sel_o = SEL_TICK; rd_legal_o = 1'b1; end
    end

endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned TICK_HZ = 24_000_000,
    parameter int unsigned CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int unsigned ACC_W = $clog2(CLK_HZ + TICK_HZ + 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = st_q.acc + ACC_W'(TICK_HZ);
        if (sum >= ACC_W'(CLK_HZ)) begin
            st_d.acc = sum - ACC_W'(CLK_HZ);
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R9
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] BOARD_ID = 32'h1100_0101,
    parameter int unsigned VARIANT  = 0,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned TICK_HZ  = 24_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              rvalid_o,
    output logic              err_o,
    output logic [31:0]       led_o,
    output logic              sys_rst_req_o
);

    localparam int unsigned TRIG_BIT = (VARIANT == 0) ? 8 : 2;
    localparam bit          HAS_RCTL = (VARIANT < 2);

    bank_state_t       st_d, st_q;
    logic [WORD_W-1:0] nv_d, nv_q;
    logic [WORD_W-1:0] tick_cnt;
    sel_e              sel;
    logic              rd_legal, wr_legal;
    logic              key_ok;
    logic              rctl_wen;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i     (addr_i),
        .sel_o      (sel),
        .rd_legal_o (rd_legal),
        .wr_legal_o (wr_legal)
    );

    sysctl_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(WORD_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (tick_cnt)
    );

    assign key_ok = (st_q.key == KEY16);

    generate
        if (HAS_RCTL) begin : g_rctl
            assign rctl_wen = wr_en_i && (sel == SEL_RCTL) && key_ok;
        end else begin : g_no_rctl
            assign rctl_wen = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d         = st_q;
        nv_d         = nv_q;
        st_d.rvalid  = rd_en_i;
        st_d.err     = (rd_en_i && !rd_legal) || (wr_en_i && !wr_legal);
        st_d.rst_req = rctl_wen && wdata_i[TRIG_BIT];
        st_d.rdata   = '0;

        if (rd_en_i) begin
            case (sel)
                SEL_ID:   st_d.rdata = BOARD_ID;
                SEL_LED:  st_d.rdata = st_q.led;
                SEL_KEY:  st_d.rdata = {16'h0000, st_q.key};
                SEL_FSET: st_d.rdata = st_q.flags;
                SEL_NSET: st_d.rdata = nv_q;
                SEL_RCTL: st_d.rdata = HAS_RCTL ? st_q.rctl : '0;
                SEL_ONE:  st_d.rdata = 32'h0000_0001;
                SEL_TICK: st_d.rdata = tick_cnt;
                default:  st_d.rdata = '0;
            endcase
        end

        if (wr_en_i) begin
            case (sel)
                SEL_LED:  st_d.led = wdata_i;
                SEL_KEY:  st_d.key = (wdata_i == KEY_WORD) ? KEY16 : {1'b0, wdata_i[14:0]};
                SEL_FSET: st_d.flags = st_q.flags | wdata_i;
                SEL_FCLR: st_d.flags = st_q.flags & ~wdata_i;
                SEL_NSET: nv_d = nv_q | wdata_i;
                SEL_NCLR: nv_d = nv_q & ~wdata_i;
                default:  ;
            endcase
        end

        if (rctl_wen) st_d.rctl = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) nv_q <= '0;
        else        nv_q <= nv_d;
    end

    assign rdata_o       = st_q.rdata;
    assign rvalid_o      = st_q.rvalid;
    assign err_o         = st_q.err;
    assign led_o         = st_q.led;
    assign sys_rst_req_o = st_q.rst_req;

    // R3
    key_bit15_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.key[15] |-> (st_q.key == KEY16));

    // R4
    rst_req_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |-> $past(wr_en_i && key_ok));

    // R7
    nv_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(wr_en_i) |-> $stable(nv_q));

    // R8
    const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && $past(sel == SEL_ONE)) |-> (rdata_o == 32'h1));

    // R10
    err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(rd_en_i || wr_en_i));

    // R11
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rvalid_o);

endmodule

// File: tb/tb_sysctl_bank.sv
module tb_sysctl_bank;

    localparam logic [31:0] ID0 = 32'h1100_0101;
    localparam logic [31:0] ID1 = 32'h2200_0202;
    localparam logic [31:0] ID2 = 32'h3300_0303;

    logic        clk = 1'b0;
    logic        rst_n, por_n, rd_en, wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata0, rdata1, rdata2, led0, led1, led2;
    logic        rv0, rv1, rv2, err0, err1, err2, req0, req1, req2;

    always #5 clk = ~clk;

    sysctl_bank #(.BOARD_ID(ID0), .VARIANT(0)) dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0), .rvalid_o(rv0),
        .err_o(err0), .led_o(led0), .sys_rst_req_o(req0));

    sysctl_bank #(.BOARD_ID(ID1), .VARIANT(1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .rvalid_o(rv1),
        .err_o(err1), .led_o(led1), .sys_rst_req_o(req1));

    sysctl_bank #(.BOARD_ID(ID2), .VARIANT(2)) dut_none (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata2), .rvalid_o(rv2),
        .err_o(err2), .led_o(led2), .sys_rst_req_o(req2));

    typedef struct {
        logic [31:0] exp;
        string       req;
        bit          cmp;
    } item_t;

    item_t       sb[$];
    item_t       it;
    logic [31:0] last_rd;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: one scoreboard entry per returned read
    always @(negedge clk) begin
        if (rv0) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                it = sb.pop_front();
                last_rd = rdata0;
                if (it.cmp) chk(rdata0 == it.exp, it.req, rdata0, it.exp);
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req, input bit cmp = 1'b1);
        item_t e;
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        e.exp = exp; e.req = req; e.cmp = cmp;
        sb.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            chk(1'b0, "watchdog", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] t1;
        rd_en = 0; wr_en = 0; addr = '0; wdata = '0; rst_n = 0; por_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(led0 == 0 && req0 == 0 && err0 == 0 && rv0 == 0, "R1 outputs", {led0[28:0], req0, err0, rv0}, 32'd0);
        rd(12'h000, ID0, "R1 id");
        rd(12'h008, 32'h0, "R1 led");
        rd(12'h020, 32'h0, "R1 key");
        rd(12'h030, 32'h0, "R1 flags");
        rd(12'h040, 32'h0, "R1 rctl");
        rd(12'h038, 32'h0, "R7 nv after por");

        // R2 LED
        wr(12'h008, 32'hDEAD_BEEF);
        chk(led0 == 32'hDEAD_BEEF, "R2 led_o", led0, 32'hDEAD_BEEF);
        rd(12'h008, 32'hDEAD_BEEF, "R2 led read");

        // R3 key register
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, 32'h0000_7FFF, "R3 non-key masked");
        wr(12'h020, 32'h0001_A05F);
        rd(12'h020, 32'h0000_205F, "R3 near-key masked");
        wr(12'h020, 32'h0000_A05F);
        rd(12'h020, 32'h0000_A05F, "R3 key stored");

        // R5 trigger bit per variant
        wr(12'h040, 32'h0000_0100);
        chk(req0 == 1'b1, "R5 v0 bit8 pulse", {31'd0, req0}, 32'd1);
        chk(req1 == 1'b0, "R5 v1 ignores bit8", {31'd0, req1}, 32'd0);
        chk(req2 == 1'b0, "R5 v2 no request", {31'd0, req2}, 32'd0);
        chk(err0 == 1'b0, "R10 legal write no err", {31'd0, err0}, 32'd0);
        @(negedge clk);
        chk(req0 == 1'b0, "R5 pulse one cycle", {31'd0, req0}, 32'd0);
        rd(12'h040, 32'h0000_0100, "R4 accepted write");
        chk(rdata2 == 32'h0, "R5 v2 reads zero", rdata2, 32'h0);
        wr(12'h040, 32'h0000_0004);
        chk(req0 == 1'b0, "R5 v0 ignores bit2", {31'd0, req0}, 32'd0);
        chk(req1 == 1'b1, "R5 v1 bit2 pulse", {31'd0, req1}, 32'd1);

        // R4 locked
        wr(12'h020, 32'h0000_1234);
        wr(12'h040, 32'h0000_0104);
        chk(req0 == 1'b0 && req1 == 1'b0, "R4 locked no request", {30'd0, req1, req0}, 32'd0);
        rd(12'h040, 32'h0000_0004, "R4 locked write ignored");

        // R6 flags
        wr(12'h030, 32'h0000_0F0F);
        wr(12'h030, 32'h0000_F000);
        rd(12'h030, 32'h0000_FF0F, "R6 set accumulates");
        wr(12'h034, 32'h0000_0F00);
        rd(12'h030, 32'h0000_F00F, "R6 clear");

        // R7 non-volatile flags
        wr(12'h038, 32'h00AA_0055);
        wr(12'h03C, 32'h0000_0005);
        rd(12'h038, 32'h00AA_0050, "R7 set/clear");
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(12'h038, 32'h00AA_0050, "R7 survives rst_n");
        rd(12'h030, 32'h0, "R1 flags cleared by rst_n");
        rd(12'h008, 32'h0, "R1 led cleared by rst_n");
        rd(12'h020, 32'h0, "R1 key cleared by rst_n");
        @(negedge clk); rst_n = 0; por_n = 0;
        @(negedge clk); rst_n = 1; por_n = 1;
        rd(12'h038, 32'h0, "R7 cleared by por_n");

        // R8 constant word
        rd(12'h044, 32'h1, "R8 reads one");
        wr(12'h044, 32'hFFFF_FFFF);
        chk(err0 == 1'b0, "R8 write no err", {31'd0, err0}, 32'd0);
        rd(12'h044, 32'h1, "R8 unchanged");

        // R9 tick rate: samples exactly 100 cycles apart
        rd(12'h05C, 32'h0, "R9", 1'b0);
        #1 t1 = last_rd;
        repeat (98) @(negedge clk);
        rd(12'h05C, 32'h0, "R9", 1'b0);
        #1 chk(last_rd - t1 == 32'd24, "R9 tick delta", last_rd - t1, 32'd24);

        // R10 undefined accesses
        rd(12'h010, 32'h0, "R10 undefined read");
        chk(err0 == 1'b1, "R10 read err pulse", {31'd0, err0}, 32'd1);
        @(negedge clk);
        chk(err0 == 1'b0, "R10 err one cycle", {31'd0, err0}, 32'd0);
        wr(12'h000, 32'h0);
        chk(err0 == 1'b1, "R10 write to id err", {31'd0, err0}, 32'd1);
        rd(12'h000, ID0, "R10 id unchanged");
        wr(12'h009, 32'h0000_00FF);
        chk(err0 == 1'b1, "R10 misaligned write err", {31'd0, err0}, 32'd1);
        chk(led0 == 32'h0, "R10 misaligned write no effect", led0, 32'h0);
        rd(12'h034, 32'h0, "R10 read of clear address");
        chk(err0 == 1'b1, "R10 clear read err", {31'd0, err0}, 32'd1);

        @(negedge clk);
        chk(sb.size() == 0, "R11 all reads returned", sb.size(), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule